// File: doc/BRIEF.md
# Quad-SPI Pseudo-Static RAM Bridge

This block sits between a simple byte-wide request bus and an external pseudo-static RAM wired through a four-lane serial link. Coming out of reset, it brings the memory into a known state. It sends a short series of single-lane commands: leave quad mode, arm the reset, apply the reset, then enter quad mode. Only after that does it accept bus traffic.

From then on, each bus request is carried out over all four lanes at single data rate. A request consists of an opcode, a 24-bit address, and a data byte. Reads also have a fixed number of turnaround clocks before the data. The serial clock runs at half the system clock. Each nibble is driven while the serial clock is low and captured while it is high.

After a byte, chip select stays low. A following request can then extend the burst with no new command, provided three things hold: it continues the same direction, it uses the next address, and it stays inside the current page. The block raises chip select when the burst reaches a page edge or when the low time would exceed the refresh limit. It also keeps chip select high for a minimum number of cycles between transactions. The requester is stalled until its byte has fully crossed the wires.

Top module: `qpsram_ctrl`

## Requirements
- R1: After reset, four commands are sent, each in its own chip-select low period: 0xF5, then 0x66, then 0x99, then 0x35. Each command is 8 bits, MSB first, on lane 0 only, so the lane enables read 4'b0001.
- R2: `bus_ready` stays low, and no request is served, until `init_done` rises after the last start-up command.
- R3: A read sends opcode 0xEB and then the 24-bit address as six nibbles, most significant first. After that come DUMMY serial clocks with all lane enables low. Two data nibbles follow, high nibble first. The byte appears on `bus_rdata` with `bus_rvalid` and `bus_ready` both high for one cycle.
- R4: A write sends opcode 0x38, the address, and then the data byte (high nibble first) immediately, with no turnaround clocks. All lane enables are high throughout.
- R5: Every quad phase moves one nibble per serial clock. Lane outputs change only while `qspi_sclk` is low, and `qspi_sclk` pulses only while chip select is low.
- R6: A request with the same direction and the next address is continued in the open burst without a new command, provided the burst is still open.
- R7: A burst never continues onto an address whose low CSBOUND bits are all zero. That byte starts a new command carrying its own address.
- R8: Chip select is never low for more than REFRESH consecutive system clocks. Bursts are split to meet this.
- R9: Chip select stays high for at least CS_HIGH_MIN system clocks before every falling edge.
- R10: `bus_ready` is a one-cycle pulse. It is issued only in the cycle after the serial clock edge that carried the last nibble, so a following write cannot be accepted before the previous one has left the link.
- R11: A request that changes direction, or that does not follow on from the previous address, closes the burst and starts a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request pending; held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 8 | Read byte, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid |
| init_done | output | 1 | Start-up sequence complete |
| qspi_sclk | output | 1 | Serial clock |
| qspi_cs_n | output | 1 | Chip select, active low |
| qspi_dout | output | 4 | Lane output values |
| qspi_oe | output | 4 | Per-lane output enables |
| qspi_din | input | 4 | Lane input values |

## Verification
The assertions assume three things about the surrounding logic. The requester holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady from the moment it raises the request until it has seen `bus_ready`. The memory side sets up `qspi_din` before the serial clock rises. REFRESH is large enough to fit one full read command plus one byte. The stimulus keeps to these rules by changing request signals only on the falling system clock right after a ready pulse. Its memory model drives each read nibble shortly after the serial clock falls, and the bench parameters leave room for a few bytes per command.

// File: rtl/qpsram_pkg.sv
package qpsram_pkg;

  typedef enum logic [2:0] {
    ST_INIT_GAP,
    ST_INIT_SHIFT,
    ST_IDLE,
    ST_CMD,
    ST_DUMMY,
    ST_DATA,
    ST_OPEN
  } qp_state_e;

  localparam logic [7:0] OP_QREAD  = 8'hEB;
  localparam logic [7:0] OP_QWRITE = 8'h38;

  // start-up commands, issued in index order
  function automatic logic [7:0] init_op(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'hF5;
      2'd1:    return 8'h66;
      2'd2:    return 8'h99;
      default: return 8'h35;
    endcase
  endfunction

endpackage

// File: rtl/qpsram_cs_timer.sv
module qpsram_cs_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  output logic [CNT_W-1:0] lo_cnt,
  output logic [CNT_W-1:0] hi_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // counts cycles already spent in the present chip-select level
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (cs_n) begin
      lo_cnt <= '0;
      if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != CNT_MAX) lo_cnt <= lo_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/qpsram_lane_out.sv
module qpsram_lane_out (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] top_nib,
  input  logic       quad,
  input  logic [3:0] oe_nxt,
  output logic [3:0] dout,
  output logic [3:0] oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 4'h0;
      oe   <= 4'h0;
    end else begin
      dout <= quad ? top_nib : {3'b000, top_nib[3]};
      oe   <= oe_nxt;
    end
  end
endmodule

// File: rtl/qpsram_ctrl.sv
module qpsram_ctrl
  import qpsram_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CSBOUND     = 10,
  parameter int REFRESH     = 872,
  parameter int CS_HIGH_MIN = 4,
  parameter int DUMMY       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              bus_ready,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic              init_done,
  output logic              qspi_sclk,
  output logic              qspi_cs_n,
  output logic [3:0]        qspi_dout,
  output logic [3:0]        qspi_oe,
  input  logic [3:0]        qspi_din
);
  localparam int SH_W      = 8 + ADDR_W;
  localparam int CMD_SLOTS = SH_W / 4;
  localparam int BYTE_CLKS = 4;
  localparam int SLOT_MAX  = (DUMMY > CMD_SLOTS) ? DUMMY : CMD_SLOTS;
  localparam int SLOT_W    = $clog2(SLOT_MAX + 1);
  localparam int CNT_W     = $clog2(REFRESH + CS_HIGH_MIN + 2);

  qp_state_e         state, state_d;
  logic [SH_W-1:0]   sh, sh_d;
  logic [SLOT_W-1:0] slots, slots_d;
  logic              ph, ph_d, sclk_d, cs_d, quad, quad_d;
  logic [3:0]        oe_d, oe_q, rd_sh, rd_d;
  logic [1:0]        idx, idx_d;
  logic              done_d, ready_d, rvalid_d, cur_we, we_d;
  logic [7:0]        rdata_d;
  logic [ADDR_W-1:0] nxt_addr, addr_d;
  logic [CNT_W-1:0]  lo_cnt, hi_cnt;
  logic              slot_end, gap_ok, room, cont;

  qpsram_cs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .cs_n(qspi_cs_n), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt)
  );

  qpsram_lane_out u_lanes (
    .clk(clk), .rst(rst), .top_nib(sh_d[SH_W-1 -: 4]), .quad(quad_d),
    .oe_nxt(oe_d), .dout(qspi_dout), .oe(qspi_oe)
  );

  assign slot_end = ph && (slots == SLOT_W'(1));
  assign gap_ok   = (32'(hi_cnt) + 32'd1) >= 32'(CS_HIGH_MIN);
  // another byte plus one closing cycle must still fit in the low window
  assign room     = (32'(lo_cnt) + 32'(BYTE_CLKS + 2)) <= 32'(REFRESH);
  assign cont     = bus_req && !bus_ready && (bus_we == cur_we) &&
                    (bus_addr == nxt_addr) && (nxt_addr[CSBOUND-1:0] != '0);

  always_comb begin
    state_d  = state;
    sh_d     = sh;
    slots_d  = slots;
    ph_d     = ph;
    sclk_d   = 1'b0;
    cs_d     = qspi_cs_n;
    quad_d   = quad;
    oe_d     = oe_q;
    idx_d    = idx;
    done_d   = init_done;
    ready_d  = 1'b0;
    rvalid_d = 1'b0;
    rdata_d  = bus_rdata;
    rd_d     = rd_sh;
    addr_d   = nxt_addr;
    we_d     = cur_we;

    if (state == ST_INIT_SHIFT || state == ST_CMD ||
        state == ST_DUMMY || state == ST_DATA) begin
      if (!ph) begin
        sclk_d = 1'b1;
        ph_d   = 1'b1;
      end else begin
        ph_d    = 1'b0;
        sh_d    = quad ? (sh << 4) : (sh << 1);
        slots_d = slots - 1'b1;
        if (state == ST_DATA && !cur_we) rd_d = qspi_din;
      end
    end

    case (state)
      ST_INIT_GAP: if (gap_ok) begin
        cs_d    = 1'b0;
        quad_d  = 1'b0;
        oe_d    = 4'b0001;
        sh_d    = {init_op(idx), {ADDR_W{1'b0}}};
        slots_d = SLOT_W'(8);
        state_d = ST_INIT_SHIFT;
      end
      ST_INIT_SHIFT: if (slot_end) begin
        cs_d  = 1'b1;
        oe_d  = 4'b0000;
        idx_d = idx + 1'b1;
        if (idx == 2'd3) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_INIT_GAP;
        end
      end
      ST_IDLE: if (bus_req && gap_ok) begin
        cs_d    = 1'b0;
        quad_d  = 1'b1;
        oe_d    = 4'b1111;
        sh_d    = {bus_we ? OP_QWRITE : OP_QREAD, bus_addr};
        slots_d = SLOT_W'(CMD_SLOTS);
        we_d    = bus_we;
        addr_d  = bus_addr;
        state_d = ST_CMD;
      end
      ST_CMD: if (slot_end) begin
        if (cur_we) begin
          sh_d    = {bus_wdata, {ADDR_W{1'b0}}};
          slots_d = SLOT_W'(2);
          state_d = ST_DATA;
        end else begin
          sh_d    = '0;
          oe_d    = 4'b0000;
          slots_d = SLOT_W'(DUMMY);
          state_d = ST_DUMMY;
        end
      end
      ST_DUMMY: if (slot_end) begin
        slots_d = SLOT_W'(2);
        state_d = ST_DATA;
      end
      ST_DATA: if (slot_end) begin
        ready_d  = 1'b1;
        rvalid_d = !cur_we;
        rdata_d  = {rd_sh, qspi_din};
        addr_d   = nxt_addr + 1'b1;
        state_d  = ST_OPEN;
      end
      ST_OPEN: begin
        if (!room || (bus_req && !bus_ready && !cont)) begin
          cs_d    = 1'b1;
          oe_d    = 4'b0000;
          state_d = ST_IDLE;
        end else if (cont) begin
          sh_d    = cur_we ? {bus_wdata, {ADDR_W{1'b0}}} : '0;
          oe_d    = cur_we ? 4'b1111 : 4'b0000;
          slots_d = SLOT_W'(2);
          state_d = ST_DATA;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_INIT_GAP;
      sh         <= '0;
      slots      <= '0;
      ph         <= 1'b0;
      qspi_sclk  <= 1'b0;
      qspi_cs_n  <= 1'b1;
      quad       <= 1'b0;
      oe_q       <= 4'b0000;
      idx        <= 2'd0;
      init_done  <= 1'b0;
      bus_ready  <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= 8'h00;
      rd_sh      <= 4'h0;
      nxt_addr   <= '0;
      cur_we     <= 1'b0;
    end else begin
      state      <= state_d;
      sh         <= sh_d;
      slots      <= slots_d;
      ph         <= ph_d;
      qspi_sclk  <= sclk_d;
      qspi_cs_n  <= cs_d;
      quad       <= quad_d;
      oe_q       <= oe_d;
      idx        <= idx_d;
      init_done  <= done_d;
      bus_ready  <= ready_d;
      bus_rvalid <= rvalid_d;
      bus_rdata  <= rdata_d;
      rd_sh      <= rd_d;
      nxt_addr   <= addr_d;
      cur_we     <= we_d;
    end
  end
endmodule

// File: rtl/qpsram_ctrl_chk.sv
module qpsram_ctrl_chk #(
  parameter int REFRESH     = 872,
  parameter int CS_HIGH_MIN = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_ready,
  input logic       bus_rvalid,
  input logic       init_done,
  input logic       qspi_sclk,
  input logic       qspi_cs_n,
  input logic [3:0] qspi_dout,
  input logic [3:0] qspi_oe
);
  logic [31:0] lo_run, hi_run;

  always_ff @(posedge clk) begin
    if (rst || qspi_cs_n) lo_run <= '0;
    else if (lo_run != '1) lo_run <= lo_run + 1'b1;
    if (rst || !qspi_cs_n) hi_run <= '0;
    else if (hi_run != '1) hi_run <= hi_run + 1'b1;
  end

  a_r1_init_single_lane: assert property (@(posedge clk) disable iff (rst)
    (!init_done && !qspi_cs_n) |-> (qspi_oe == 4'b0001));

  a_r2_no_ready_before_init: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !bus_ready);

  a_r3_rvalid_with_ready: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> bus_ready);

  a_r5_lanes_stable_sclk_high: assert property (@(posedge clk) disable iff (rst)
    qspi_sclk |-> $stable(qspi_dout));

  a_r5_sclk_only_selected: assert property (@(posedge clk) disable iff (rst)
    qspi_sclk |-> !qspi_cs_n);

  a_r8_refresh_limit: assert property (@(posedge clk) disable iff (rst)
    !qspi_cs_n |-> (lo_run < 32'(REFRESH)));

  a_r9_cs_high_min: assert property (@(posedge clk) disable iff (rst)
    $fell(qspi_cs_n) |-> (hi_run >= 32'(CS_HIGH_MIN)));

  a_r10_ready_after_last_clock: assert property (@(posedge clk) disable iff (rst)
    bus_ready |-> ($past(qspi_sclk) && !qspi_sclk && !qspi_cs_n));

  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready);
endmodule

bind qpsram_ctrl qpsram_ctrl_chk #(.REFRESH(REFRESH), .CS_HIGH_MIN(CS_HIGH_MIN)) u_chk (
  .clk(clk), .rst(rst), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
  .init_done(init_done), .qspi_sclk(qspi_sclk), .qspi_cs_n(qspi_cs_n),
  .qspi_dout(qspi_dout), .qspi_oe(qspi_oe)
);

// File: tb/qpsram_ctrl_tb_top.sv
module qpsram_ctrl_tb_top;
  localparam int CSB = 4, REF = 60, CSH = 3, DUM = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic bus_ready, bus_rvalid, init_done, qspi_sclk, qspi_cs_n;
  logic [3:0] qspi_dout, qspi_oe, qspi_din = 4'h0;

  always #4 clk = ~clk;

  qpsram_ctrl #(.ADDR_W(24), .CSBOUND(CSB), .REFRESH(REF), .CS_HIGH_MIN(CSH), .DUMMY(DUM)) dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .init_done(init_done), .qspi_sclk(qspi_sclk),
    .qspi_cs_n(qspi_cs_n), .qspi_dout(qspi_dout), .qspi_oe(qspi_oe), .qspi_din(qspi_din)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // ---------------- memory model ----------------
  bit [7:0] mmem [int];
  int rises = 0, oe_err = 0;
  bit quad = 0;
  logic [7:0] sh8 = 0, mop = 0, wbuf = 0;
  logic [23:0] maddr = 0, mstart = 0;
  logic [7:0] init_log[$];
  logic [31:0] cmd_log[$];

  function automatic bit [7:0] mget(input int a);
    return mmem.exists(a) ? mmem[a] : 8'h00;
  endfunction

  always @(negedge qspi_cs_n) rises = 0;

  always @(posedge qspi_cs_n) if (rises > 0) begin
    if (!quad) begin
      init_log.push_back(sh8);
      if (sh8 == 8'h35) quad = 1;
    end else cmd_log.push_back({mop, mstart});
  end

  always @(posedge qspi_sclk) begin
    rises++;
    if (!quad) begin
      sh8 = {sh8[6:0], qspi_dout[0]};
      if (qspi_oe !== 4'b0001) oe_err++;
    end else if (rises <= 2) begin
      mop = {mop[3:0], qspi_dout};
      if (qspi_oe !== 4'hF) oe_err++;
    end else if (rises <= 8) begin
      maddr = {maddr[19:0], qspi_dout};
      if (qspi_oe !== 4'hF) oe_err++;
      if (rises == 8) mstart = maddr;
    end else if (mop == 8'h38) begin
      if (qspi_oe !== 4'hF) oe_err++;
      wbuf = {wbuf[3:0], qspi_dout};
      if (rises % 2 == 0) begin
        mmem[int'(maddr)] = wbuf;
        maddr = maddr + 1;
      end
    end else if (qspi_oe !== 4'h0) oe_err++;
  end

  always @(negedge qspi_sclk) begin
    if (quad && mop == 8'hEB && rises >= 8 + DUM) begin
      int k;
      bit [7:0] b;
      k = rises - (8 + DUM);
      b = mget(int'(mstart) + k / 2);
      qspi_din <= #1 ((k % 2) == 0) ? b[7:4] : b[3:0];
    end
  end

  // ---------------- scoreboard ----------------
  bit [7:0] ref_mem [int];
  logic [7:0] exp_q[$];
  int early_ready = 0;

  function automatic bit [7:0] rget(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  task automatic xfer(input bit we, input int a, input bit [7:0] d);
    bus_req = 1; bus_we = we; bus_addr = 24'(a); bus_wdata = d;
    if (we) ref_mem[a] = d; else exp_q.push_back(rget(a));
    do @(negedge clk); while (!bus_ready);
    bus_req = 0;
  endtask

  // R3 / R10: monitor compares every returned read byte
  always @(negedge clk) begin
    if (!rst && bus_ready && !init_done) early_ready++;
    if (bus_rvalid) begin
      logic [7:0] e;
      if (exp_q.size() == 0) chk(0, "R3 unexpected read", bus_rdata, 0);
      else begin
        e = exp_q.pop_front();
        chk(bus_rdata == e, "R3 read data", bus_rdata, e);
      end
    end
  end

  // chip-select run lengths for R8 / R9
  int lo_run = 0, hi_run = 0, max_lo = 0, min_hi = 1000000;
  logic prev_cs = 1'b1;
  always @(negedge clk) if (!rst) begin
    if (qspi_cs_n) hi_run++;
    else begin
      if (prev_cs && hi_run < min_hi) min_hi = hi_run;
      hi_run = 0;
    end
    if (!qspi_cs_n) begin
      lo_run++;
      if (lo_run > max_lo) max_lo = lo_run;
    end else lo_run = 0;
    prev_cs = qspi_cs_n;
  end

  task automatic wait_idle();
    int n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (qspi_cs_n) n++; else n = 0;
      if (n >= 4) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // request held from reset: must wait for start-up (R2)
    bus_req = 1; bus_we = 0; bus_addr = 24'h0;
    repeat (4) @(negedge clk);
    chk(qspi_cs_n == 1 && bus_ready == 0 && init_done == 0 && qspi_sclk == 0,
        "reset state", {qspi_cs_n, bus_ready, init_done, qspi_sclk}, 4'b1000);
    rst = 0;
    xfer(0, 0, 0);
    chk(early_ready == 0, "R2 ready before init", early_ready, 0);
    chk(init_done == 1, "R2 init_done", init_done, 1);
    chk(init_log.size() == 4, "R1 command count", init_log.size(), 4);
    if (init_log.size() == 4) begin
      chk(init_log[0] == 8'hF5, "R1 cmd0", init_log[0], 8'hF5);
      chk(init_log[1] == 8'h66, "R1 cmd1", init_log[1], 8'h66);
      chk(init_log[2] == 8'h99, "R1 cmd2", init_log[2], 8'h99);
      chk(init_log[3] == 8'h35, "R1 cmd3", init_log[3], 8'h35);
    end

    // R4 write then R3 read back
    for (int i = 0; i < 8; i++) xfer(1, 'h100 + i, 8'(8'h5A + 13 * i));
    for (int i = 0; i < 8; i++) xfer(0, 'h100 + i, 0);
    wait_idle();

    // R7 page crossing: 0x22C..0x231 with 16-byte pages
    cmd_log.delete();
    for (int i = 0; i < 6; i++) xfer(1, 'h22C + i, 8'(8'hC3 ^ i));
    wait_idle();
    chk(cmd_log.size() == 2, "R7 command count", cmd_log.size(), 2);
    if (cmd_log.size() == 2) begin
      chk(cmd_log[0] == {8'h38, 24'h22C}, "R4 first write cmd", cmd_log[0], {8'h38, 24'h22C});
      chk(cmd_log[1] == {8'h38, 24'h230}, "R7 restart address", cmd_log[1], {8'h38, 24'h230});
    end
    for (int i = 0; i < 6; i++)
      chk(mget('h22C + i) == 8'(8'hC3 ^ i), "R4 stored byte", mget('h22C + i), 8'(8'hC3 ^ i));

    // R6 sequential read burst in one command
    cmd_log.delete();
    for (int i = 0; i < 4; i++) xfer(0, 'h100 + i, 0);
    wait_idle();
    chk(cmd_log.size() == 1, "R6 burst command count", cmd_log.size(), 1);
    if (cmd_log.size() == 1)
      chk(cmd_log[0] == {8'hEB, 24'h100}, "R3 read cmd", cmd_log[0], {8'hEB, 24'h100});

    // R8 long burst inside one page is split by the refresh limit
    cmd_log.delete();
    for (int i = 0; i < 16; i++) xfer(1, 'h300 + i, 8'(3 * i + 1));
    wait_idle();
    chk(cmd_log.size() >= 2, "R8 split count", cmd_log.size(), 2);
    for (int i = 0; i < 16; i++) xfer(0, 'h300 + i, 0);
    wait_idle();

    // R11 direction changes force new commands
    cmd_log.delete();
    xfer(1, 'h400, 8'h77);
    xfer(0, 'h401, 0);
    xfer(1, 'h402, 8'h88);
    xfer(1, 'h410 + 5, 8'h99);
    wait_idle();
    chk(cmd_log.size() == 4, "R11 command count", cmd_log.size(), 4);

    // mixed pattern
    for (int i = 0; i < 24; i++) xfer(1, (i * 37) & 'hFFF, 8'(i * 29 + 7));
    for (int i = 23; i >= 0; i--) xfer(0, (i * 37) & 'hFFF, 0);
    wait_idle();

    chk(oe_err == 0, "R5 lane enables per phase", oe_err, 0);
    chk(max_lo <= REF, "R8 max low time", max_lo, REF);
    chk(min_hi >= CSH, "R9 min high time", min_hi, CSH);
    chk(exp_q.size() == 0, "R10 reads outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule